// File: doc/BRIEF.md
# Host Write Posting Cycle Controller

This block sits on a pipelined processor host bus and decides how every host write cycle is terminated. When it samples an address strobe for a write, it captures the address, the low 32-bit data word and the memory/I-O qualifier. In the next clock it asks the host for the next address early, so the host can place a new cycle on the bus without an idle clock.

Memory writes are posted into an internal write FIFO and are acknowledged after one wait state. A downstream bus engine drains that FIFO through a pop interface. I/O writes are never posted. Each one waits until every earlier posted write has left the FIFO. It is then presented to the downstream engine, and the host is acknowledged only after the downstream target reports completion. I/O writes that fall in the bridge's own register window are acknowledged locally and produce no downstream activity.

Top module: `host_wpost_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `hst_nxt`, `hst_rdy`, `io_req` and `pw_valid` are all 0, and the FIFO holds no entries.
- R2: A strobe with `hst_write`=1 that arrives while the block is idle makes `hst_nxt` high for exactly one clock, the clock right after the strobe.
- R3: A memory write (`hst_io`=0) with room in the FIFO raises `hst_rdy` for one clock in the second clock after the strobe. In that same clock it pushes {address, `hst_data_lo`} into the FIFO.
- R4: A new strobe presented in the clock right after `hst_rdy` is accepted, so back-to-back memory writes take three clocks each with no idle clock between them.
- R5: While the FIFO holds DEPTH entries, a pending memory write keeps `hst_rdy` low and pushes nothing. In the clock after a pop frees an entry, it completes with `hst_rdy` and the push.
- R6: An I/O write (`hst_io`=1) outside the local window is never pushed into the FIFO. It is presented on `io_req`, `io_addr` and `io_data` instead.
- R7: `io_req` stays 0 until the FIFO is empty, so an I/O write never overtakes an earlier posted memory write.
- R8: `io_done` counts only while `io_req` is high. `hst_rdy` is raised in the clock after `io_done` is sampled with `io_req` high, and `io_req` is low from that clock on.
- R9: An I/O write whose address bits above bit WIN_W-1 match LOC_BASE (default window 0x0CF0 to 0x0CFF) is local. It raises `hst_rdy` in the second clock after the strobe, with no push and no `io_req`. A memory write to the same addresses is posted normally.
- R10: A strobe with `hst_write`=0 is ignored, and so is a strobe while a cycle is still open. Neither raises `hst_nxt` or `hst_rdy`, and neither pushes anything.
- R11: `pw_valid` is high whenever the FIFO is not empty. `pw_addr` and `pw_data` show the oldest entry, and entries leave in push order, one per clock in which `pw_pop` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_strobe | input | 1 | Host address strobe, one clock per cycle |
| hst_write | input | 1 | 1 = write cycle |
| hst_io | input | 1 | 1 = I/O space, 0 = memory space |
| hst_addr | input | AW | Host cycle address |
| hst_data_lo | input | 32 | Low 32-bit word of the host write data |
| hst_nxt | output | 1 | Early next-address request to the host |
| hst_rdy | output | 1 | Cycle termination (ready) to the host |
| pw_valid | output | 1 | FIFO holds at least one posted write |
| pw_addr | output | AW | Address of the oldest posted write |
| pw_data | output | 32 | Data of the oldest posted write |
| pw_pop | input | 1 | Downstream engine removes the oldest entry |
| io_req | output | 1 | Non-posted I/O write presented downstream |
| io_addr | output | AW | I/O write address |
| io_data | output | 32 | I/O write data |
| io_done | input | 1 | Downstream target-ready for the I/O write |

## Verification
The hardest situation to reach is an I/O write that is held behind a full FIFO while a further memory write has already stalled on that full FIFO. The ordering rule and the full-stall rule then interact with a downstream side that is idle on purpose. The stimulus gets there by posting back-to-back writes with `pw_pop` low until the FIFO is full. It then opens one more memory write and releases a single pop. After that it issues an I/O write and holds off the drain for several clocks before popping everything and answering `io_done` late. A stray `io_done` with no request outstanding, and a strobe aimed at a cycle that is still open, are also driven, to show that both are ignored.

// File: rtl/wpost_pkg.sv
// Shared types for the host write posting controller.
package wpost_pkg;
    // Cycle states of the termination sequencer.
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for an address strobe
        ST_NA,     // clock after strobe: early next-address
        ST_MEM,    // memory write: post when FIFO has room
        ST_LOC,    // local register access: ack without forwarding
        ST_IO,     // I/O write: wait for drain, then request downstream
        ST_IOEND   // I/O completion seen: ack host
    } wp_state_e;
endpackage

// File: rtl/wpost_decode.sv
// Local window decode.
// Flags an I/O access whose upper address bits match the bridge's own
// register window. Assumes the window is aligned to 2**WIN_W bytes.
module wpost_decode #(
    parameter int          AW       = 32,
    parameter int          WIN_W    = 4,
    parameter logic [31:0] LOC_BASE = 32'h0000_0CF0
) (
    input  logic [AW-1:WIN_W] addr_hi,
    input  logic              is_io,
    output logic              local_hit
);
    localparam logic [AW-1:0] BASE_EXT = AW'(LOC_BASE);

    // Compare the upper address bits against the window base.
    always_comb begin
        local_hit = is_io && (addr_hi == BASE_EXT[AW-1:WIN_W]);
    end
endmodule

// File: rtl/wpost_fifo.sv
// Posted write FIFO.
// Holds {address, low data word} entries in push order. A push while full
// and a pop while empty are both ignored. The head is shown combinationally
// from storage.
module wpost_fifo #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic          valid,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic          full,
    output logic          empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [AW-1:0] mem_a [DEPTH];
    logic [DW-1:0] mem_d [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          push_ok, pop_ok;

    // Qualify requests against occupancy.
    always_comb begin
        full    = (count == CW'(DEPTH));
        empty   = (count == '0);
        valid   = !empty;
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        head_addr = mem_a[rd_ptr];
        head_data = mem_d[rd_ptr];
    end

    // Advance pointers and occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(push_ok) - CW'(pop_ok);
        end
    end

    // Write entry storage.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem_a[wr_ptr] <= push_addr;
            mem_d[wr_ptr] <= push_data;
        end
    end

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R11
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
endmodule

// File: rtl/wpost_fsm.sv
// Cycle termination sequencer.
// Accepts a host write strobe when idle, asks for the next address one clock
// later, then posts a memory write, acks a local access, or runs a
// non-posted I/O write after the FIFO drains. Assumes the host raises the
// strobe for one clock per cycle.
module wpost_fsm
    import wpost_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hst_strobe,
    input  logic          hst_write,
    input  logic          hst_io,
    input  logic [AW-1:0] hst_addr,
    input  logic [31:0]   hst_data_lo,
    input  logic          local_hit,
    input  logic          fifo_full,
    input  logic          fifo_empty,
    input  logic          io_done,
    output logic          nxt,
    output logic          rdy,
    output logic          push,
    output logic          io_req,
    output logic          cap_io,
    output logic [AW-1:0] cap_addr,
    output logic [31:0]   cap_data
);
    wp_state_e state, state_nx;
    logic      accept;

    // Decode Moore outputs and next state.
    always_comb begin
        accept   = (state == ST_IDLE) && hst_strobe && hst_write;
        nxt      = (state == ST_NA);
        push     = (state == ST_MEM) && !fifo_full;
        io_req   = (state == ST_IO) && fifo_empty;
        rdy      = push || (state == ST_LOC) || (state == ST_IOEND);
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept) state_nx = ST_NA;
            ST_NA:    state_nx = !cap_io ? ST_MEM : (local_hit ? ST_LOC : ST_IO);
            ST_MEM:   if (push) state_nx = ST_IDLE;
            ST_LOC:   state_nx = ST_IDLE;
            ST_IO:    if (io_req && io_done) state_nx = ST_IOEND;
            ST_IOEND: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Capture cycle attributes at strobe acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_io   <= 1'b0;
            cap_addr <= '0;
            cap_data <= '0;
        end else if (accept) begin
            cap_io   <= hst_io;
            cap_addr <= hst_addr;
            cap_data <= hst_data_lo;
        end
    end

    // R2
    nxt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && hst_strobe && hst_write) |=> nxt);

    // R2
    nxt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nxt |=> !nxt);

    // R3
    mem_one_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nxt && !cap_io) |=> (rdy == !fifo_full));

    // R7
    io_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_req |-> fifo_empty);

    // R8
    io_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && io_done) |=> (rdy && !io_req));
endmodule

// File: rtl/host_wpost_ctrl.sv
// Host write posting cycle controller (top).
// Connects the termination sequencer, the local window decode and the
// posted write FIFO. The downstream engine pops posted writes and answers
// non-posted I/O writes with io_done.
module host_wpost_ctrl #(
    parameter int          AW       = 32,
    parameter int          DEPTH    = 4,
    parameter int          WIN_W    = 4,
    parameter logic [31:0] LOC_BASE = 32'h0000_0CF0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hst_strobe,
    input  logic          hst_write,
    input  logic          hst_io,
    input  logic [AW-1:0] hst_addr,
    input  logic [31:0]   hst_data_lo,
    output logic          hst_nxt,
    output logic          hst_rdy,
    output logic          pw_valid,
    output logic [AW-1:0] pw_addr,
    output logic [31:0]   pw_data,
    input  logic          pw_pop,
    output logic          io_req,
    output logic [AW-1:0] io_addr,
    output logic [31:0]   io_data,
    input  logic          io_done
);
    logic          local_hit, fifo_full, fifo_empty, push, cap_io;
    logic [AW-1:0] cap_addr;
    logic [31:0]   cap_data;

    wpost_fsm #(.AW(AW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .hst_strobe(hst_strobe), .hst_write(hst_write), .hst_io(hst_io),
        .hst_addr(hst_addr), .hst_data_lo(hst_data_lo),
        .local_hit(local_hit), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
        .io_done(io_done),
        .nxt(hst_nxt), .rdy(hst_rdy), .push(push), .io_req(io_req),
        .cap_io(cap_io), .cap_addr(cap_addr), .cap_data(cap_data)
    );

    wpost_decode #(.AW(AW), .WIN_W(WIN_W), .LOC_BASE(LOC_BASE)) u_dec (
        .addr_hi(cap_addr[AW-1:WIN_W]), .is_io(cap_io), .local_hit(local_hit)
    );

    wpost_fifo #(.AW(AW), .DW(32), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_addr(cap_addr), .push_data(cap_data),
        .pop(pw_pop),
        .valid(pw_valid), .head_addr(pw_addr), .head_data(pw_data),
        .full(fifo_full), .empty(fifo_empty)
    );

    // Present the captured I/O write downstream.
    always_comb begin
        io_addr = cap_addr;
        io_data = cap_data;
    end

    // R6
    io_not_posted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push |-> !cap_io) and (io_req |-> !push));

    // R9
    local_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_nxt && local_hit) |=> (hst_rdy && !push && !io_req));
endmodule

// File: tb/sim_host_wpost_ctrl.sv
// Bench: behavioural reference model compared with the design on every clock.
module sim_host_wpost_ctrl;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_strobe = 1'b0, hst_write = 1'b0, hst_io = 1'b0;
    logic [31:0] hst_addr = '0, hst_data_lo = '0;
    logic        pw_pop = 1'b0, io_done = 1'b0;
    logic        hst_nxt, hst_rdy, pw_valid, io_req;
    logic [31:0] pw_addr, pw_data, io_addr, io_data;

    int    checks = 0, errors = 0, cyc = 0;
    string cur = "R3";
    bit    done = 0;

    host_wpost_ctrl #(.AW(32), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .hst_strobe(hst_strobe), .hst_write(hst_write),
        .hst_io(hst_io), .hst_addr(hst_addr), .hst_data_lo(hst_data_lo),
        .hst_nxt(hst_nxt), .hst_rdy(hst_rdy), .pw_valid(pw_valid),
        .pw_addr(pw_addr), .pw_data(pw_data), .pw_pop(pw_pop),
        .io_req(io_req), .io_addr(io_addr), .io_data(io_data), .io_done(io_done)
    );

    always #5 clk = ~clk;

    // Reference model state: phase number, captured cycle, posted queue.
    int          ms = 0;
    logic [31:0] ma = '0, md = '0;
    bit          mio = 0;
    logic [63:0] q[$];

    function automatic bit m_local(logic [31:0] a);
        return (a & 32'hFFFF_FFF0) == 32'h0000_0CF0;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            ms = 0;
            q.delete();
        end else begin
            bit do_pop, do_push;
            do_pop  = pw_pop && q.size() != 0;
            do_push = (ms == 2) && (q.size() < DEPTH);
            case (ms)
                0: if (hst_strobe && hst_write) begin
                       ms = 1; ma = hst_addr; md = hst_data_lo; mio = hst_io;
                   end
                1: ms = !mio ? 2 : (m_local(ma) ? 3 : 4);
                2: if (do_push) ms = 0;
                3: ms = 0;
                4: if (q.size() == 0 && io_done) ms = 5;
                5: ms = 0;
                default: ms = 0;
            endcase
            if (do_pop)  void'(q.pop_front());
            if (do_push) q.push_back({ma, md});
        end
    end

    task automatic chk(string tag, string nm, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", tag, nm, act, exp, cyc);
        end
    endtask

    // Compare all outputs against the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic e_rdy, e_ioreq;
            e_rdy   = (ms == 2 && q.size() < DEPTH) || ms == 3 || ms == 5;
            e_ioreq = (ms == 4) && q.size() == 0;
            chk("R2", "hst_nxt", hst_nxt, ms == 1);
            chk(cur, "hst_rdy", hst_rdy, e_rdy);
            chk("R7", "io_req", io_req, e_ioreq);
            chk("R11", "pw_valid", pw_valid, q.size() != 0);
            if (q.size() != 0) begin
                chk("R11", "pw_addr", pw_addr, q[0][63:32]);
                chk("R11", "pw_data", pw_data, q[0][31:0]);
            end
            if (e_ioreq) begin
                chk("R6", "io_addr", io_addr, ma);
                chk("R6", "io_data", io_data, md);
            end
        end
    end

    task automatic strobe(logic [31:0] a, logic [31:0] d, bit io, bit wr);
        @(negedge clk);
        hst_strobe = 1; hst_addr = a; hst_data_lo = d; hst_io = io; hst_write = wr;
        @(negedge clk);
        hst_strobe = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        chk("R1", "reset outputs", {hst_nxt, hst_rdy, io_req, pw_valid}, 4'b0);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "post-reset outputs", {hst_nxt, hst_rdy, io_req, pw_valid}, 4'b0);

        // R3: single posted memory write
        cur = "R3";
        strobe(32'h0000_1000, 32'hA5A5_0001, 0, 1);
        idle(3);

        // R4: back-to-back memory writes, three clocks each (fills FIFO)
        cur = "R4";
        for (int i = 0; i < 3; i++) begin
            strobe(32'h0000_2000 + 32'(i * 4), 32'hB000_0000 + 32'(i), 0, 1);
            idle(1);
        end
        idle(2);

        // R5: memory write against a full FIFO, freed by one pop
        cur = "R5";
        strobe(32'h0000_3000, 32'hC0C0_C0C0, 0, 1);
        idle(5);
        pw_pop = 1; @(negedge clk); pw_pop = 0;
        idle(3);

        // R7/R8: I/O write held behind posted writes, late completion
        cur = "R8";
        io_done = 1; @(negedge clk); io_done = 0;   // stray completion, ignored
        strobe(32'h0000_0400, 32'hD1D1_0002, 1, 1);
        idle(6);
        pw_pop = 1;
        idle(6);
        pw_pop = 0;
        idle(2);
        io_done = 1; @(negedge clk); io_done = 0;
        idle(3);

        // R9: local I/O window, then memory write to the same address
        cur = "R9";
        strobe(32'h0000_0CF4, 32'hE000_0001, 1, 1);
        idle(3);
        strobe(32'h0000_0CF8, 32'hE000_0002, 0, 1);
        idle(3);

        // R10: read strobe ignored, strobe during open cycle ignored
        cur = "R10";
        strobe(32'h0000_5000, 32'hF000_0001, 0, 0);
        idle(3);
        strobe(32'h0000_6000, 32'hF000_0002, 0, 1);
        hst_strobe = 1; hst_addr = 32'h0000_7000; hst_write = 1;
        @(negedge clk); hst_strobe = 0;
        idle(4);

        // R11: drain in order
        cur = "R11";
        pw_pop = 1;
        idle(6);
        pw_pop = 0;
        idle(2);
        finish_run();
    end
endmodule